// File: doc/BRIEF.md
# Fault Status Latch with Read-Qualified Clear

This block holds an interrupt status word for a hardware monitor. Seven monitor channels each supply a live out-of-limit flag. When a flag is active at a clock edge, the matching status bit latches and stays set. Host software polls the word through a read strobe. A read clears a latched bit only if the fault behind it has gone away. A condition that is still present therefore cannot be lost by reading it.

The top bit is not latched. It is a summary that follows the OR of an auxiliary status vector, which is the contents of a second status register kept elsewhere. Software can test this one bit to learn whether that second register needs a visit. The lowest channel has two possible sources. A configuration input selects either the supply-limit flag or a thermal-timer expiry signal. The interrupt request is raised whenever any of the eight bits is set. The limit comparators and the host bus protocol are outside this block.

Top module: `fault_stat_reg`

## Requirements
- R1: After synchronous reset, every latched bit, the summary bit, `rd_data` and `irq` are 0.
- R2: Status word layout (default parameters): bit 0 is the 2.5 V supply or thermal-timer channel, bit 1 the processor core supply, bit 2 the main supply, bit 3 the 5 V supply, bit 4 remote sensor 1, bit 5 local temperature, bit 6 remote sensor 2, and bit 7 the summary. Bit k (k < 7) follows `mon_flt[k]`, except bit 0 in timer mode.
- R3: A channel source active at a rising edge sets its bit, visible from that edge on. The bit stays set across any number of edges without a read.
- R4: At an edge with `rd_stb` high, a latched bit clears if its source is inactive at that edge. It stays set if its source is active, including a source that first becomes active in that same cycle.
- R5: At an edge with `rd_stb` high, `rd_data` loads the eight-bit word as it stood before that edge, which is before any clear the read causes. Between reads, `rd_data` holds its value.
- R6: The summary bit (bit 7) equals the OR of `aux_stat` sampled at the previous edge. A read never clears it.
- R7: When `b0_sel_tmr` is 1, bit 0 takes its source from `therm_tmr_hit` and ignores `mon_flt[0]`. When it is 0, bit 0 takes `mon_flt[0]` and ignores `therm_tmr_hit`.
- R8: `irq` is 1 exactly when at least one of the eight status bits is currently 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_flt | input | NUM_CH (7) | Live out-of-limit flag per monitor channel |
| therm_tmr_hit | input | 1 | Thermal timer limit exceeded (alternate bit 0 source) |
| b0_sel_tmr | input | 1 | 1 selects the timer as the bit 0 source |
| aux_stat | input | AUX_W (8) | Contents of the second status register |
| rd_stb | input | 1 | One-cycle read strobe for this status word |
| rd_data | output | NUM_CH+1 (8) | Word captured by the most recent read |
| irq | output | 1 | Interrupt request: OR of all status bits |

## Verification
The bench builds the block with its defaults, seven channels and an eight-bit auxiliary vector. At these values the whole word layout is covered: each channel position is checked, the bit 0 source select is checked in both modes, and the summary is checked in the top bit. Across a run of reads, a scoreboard model tracks the latched word. This makes reachable the cases where a read decides between clearing and holding: a fault still active at the read, a fault that rises in the read cycle, and a summary that survives repeated reads.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned CH_DEFAULT  = 7;
  localparam int unsigned AUX_DEFAULT = 8;

  typedef enum logic {
    B0_SRC_VOLT  = 1'b0,
    B0_SRC_TIMER = 1'b1
  } b0_src_e;
endpackage

// File: rtl/fsr_src_sel.sv
module fsr_src_sel
  import fsr_pkg::*;
#(
  parameter int unsigned NUM_CH = CH_DEFAULT
) (
  input  logic [NUM_CH-1:0] mon_flt,
  input  logic              therm_tmr_hit,
  input  logic              b0_sel_tmr,
  output logic [NUM_CH-1:0] src
);
  b0_src_e b0_mode;

  always_comb begin
    b0_mode = b0_src_e'(b0_sel_tmr);
    src     = mon_flt;
    if (b0_mode == B0_SRC_TIMER) src[0] = therm_tmr_hit;
  end
endmodule

// File: rtl/fsr_sticky_cell.sv
module fsr_sticky_cell (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic rd,
  output logic st_q
);
  always_ff @(posedge clk) begin
    if (rst) st_q <= 1'b0;
    else     st_q <= src | (st_q & ~rd);
  end

  // R3: an active source sets the bit
  a_r3_set_on_fault: assert property (@(posedge clk) disable iff (rst)
    src |=> st_q);
  // R3: with no read, a set bit stays set
  a_r3_hold_no_read: assert property (@(posedge clk) disable iff (rst)
    (st_q && !rd) |=> st_q);
  // R4: a read with the source gone clears the bit
  a_r4_clear_when_gone: assert property (@(posedge clk) disable iff (rst)
    (rd && !src) |=> !st_q);
endmodule

// File: rtl/fsr_summary.sv
module fsr_summary
  import fsr_pkg::*;
#(
  parameter int unsigned AUX_W = AUX_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AUX_W-1:0] aux_stat,
  output logic             sum_q
);
  always_ff @(posedge clk) begin
    if (rst) sum_q <= 1'b0;
    else     sum_q <= |aux_stat;
  end

  // R6: any set auxiliary bit shows in the summary one edge later
  a_r6_sum_rises: assert property (@(posedge clk) disable iff (rst)
    (aux_stat != '0) |=> sum_q);
  // R6: a clear auxiliary vector drops the summary one edge later
  a_r6_sum_falls: assert property (@(posedge clk) disable iff (rst)
    (aux_stat == '0) |=> !sum_q);
endmodule

// File: rtl/fault_stat_reg.sv
module fault_stat_reg
  import fsr_pkg::*;
#(
  parameter int unsigned NUM_CH = CH_DEFAULT,
  parameter int unsigned AUX_W  = AUX_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] mon_flt,
  input  logic              therm_tmr_hit,
  input  logic              b0_sel_tmr,
  input  logic [AUX_W-1:0]  aux_stat,
  input  logic              rd_stb,
  output logic [NUM_CH:0]   rd_data,
  output logic              irq
);
  localparam int unsigned REG_W   = NUM_CH + 1;
  localparam int unsigned SUM_BIT = NUM_CH;

  logic [NUM_CH-1:0] src;
  logic [NUM_CH-1:0] st_vec;
  logic              sum_q;
  logic [REG_W-1:0]  word;

  fsr_src_sel #(.NUM_CH(NUM_CH)) u_sel (
    .mon_flt      (mon_flt),
    .therm_tmr_hit(therm_tmr_hit),
    .b0_sel_tmr   (b0_sel_tmr),
    .src          (src)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_cell
    fsr_sticky_cell u_cell (
      .clk (clk),
      .rst (rst),
      .src (src[k]),
      .rd  (rd_stb),
      .st_q(st_vec[k])
    );
  end

  fsr_summary #(.AUX_W(AUX_W)) u_sum (
    .clk     (clk),
    .rst     (rst),
    .aux_stat(aux_stat),
    .sum_q   (sum_q)
  );

  always_comb begin
    word          = '0;
    word[NUM_CH-1:0] = st_vec;
    word[SUM_BIT] = sum_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= word;
  end

  assign irq = |word;

  // R5: read data holds between reads
  a_r5_hold_between_reads: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));
  // R8: any channel fault raises the request on the next edge
  a_r8_fault_raises_irq: assert property (@(posedge clk) disable iff (rst)
    (src != '0) |=> irq);
  // R7: in timer mode the timer input sets bit 0
  a_r7_timer_sets_b0: assert property (@(posedge clk) disable iff (rst)
    (b0_sel_tmr && therm_tmr_hit) |=> st_vec[0]);
  // R6: a read leaves the summary set while the auxiliary vector stays set
  a_r6_read_keeps_sum: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && sum_q && aux_stat != '0) |=> sum_q);
endmodule

// File: tb/sim_fault_stat_reg.sv
module sim_fault_stat_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 7;
  localparam int AW  = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] mon_flt = '0;
  logic           therm_tmr_hit = 1'b0;
  logic           b0_sel_tmr = 1'b0;
  logic [AW-1:0]  aux_stat = '0;
  logic           rd_stb = 1'b0;
  logic [NCH:0]   rd_data;
  logic           irq;

  fault_stat_reg #(.NUM_CH(NCH), .AUX_W(AW)) u0 (
    .clk(clk), .rst(rst), .mon_flt(mon_flt), .therm_tmr_hit(therm_tmr_hit),
    .b0_sel_tmr(b0_sel_tmr), .aux_stat(aux_stat), .rd_stb(rd_stb),
    .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int           due;
    int           req;
    logic [NCH:0] rd;
    logic         irq;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [NCH-1:0] m_st = '0;
  logic           m_sum = 1'b0;
  logic [NCH:0]   m_rd = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare each expected item in the cycle it falls due
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].due == cyc) begin
      e = q.pop_front();
      n_chk++;
      if (rd_data !== e.rd) begin
        n_bad++;
        $display("FAIL R%0d rd_data actual=%h expected=%h", e.req, rd_data, e.rd);
      end
      n_chk++;
      if (irq !== e.irq) begin
        n_bad++;
        // R8: request is the OR of the current word
        $display("FAIL R8 irq actual=%b expected=%b", irq, e.irq);
      end
    end
  end

  // driver: apply one cycle of stimulus and push the model's outcome
  task automatic step(input logic [NCH-1:0] f, input logic t, input logic m,
                      input logic [AW-1:0] a, input logic r, input int req);
    exp_t e;
    logic [NCH-1:0] s;
    mon_flt = f; therm_tmr_hit = t; b0_sel_tmr = m; aux_stat = a; rd_stb = r;
    s = f;
    if (m) s[0] = t;
    if (r) m_rd = {m_sum, m_st};
    m_st  = s | (m_st & ~{NCH{r}});
    m_sum = |a;
    e.due = cyc + 1;
    e.req = req;
    e.rd  = m_rd;
    e.irq = m_sum | (|m_st);
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs clear after reset
    n_chk++;
    if (rd_data !== '0 || irq !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%h/%b expected=00/0", rd_data, irq);
    end
    step('0, 0, 0, '0, 1, 1);                 // R1: read straight after reset

    for (int k = 1; k < NCH; k++) begin       // R2 R3 R4: each channel position
      step(NCH'(1) << k, 0, 0, '0, 0, 2);
      step('0, 0, 0, '0, 1, 2);
      step('0, 0, 0, '0, 1, 4);
    end
    step(7'h01, 0, 0, '0, 0, 2);              // R2: bit 0 in supply mode
    step('0, 0, 0, '0, 1, 2);
    step('0, 0, 0, '0, 1, 4);

    step(7'h10, 0, 0, '0, 0, 3);              // R3: held over idle cycles
    for (int i = 0; i < 3; i++) step('0, 0, 0, '0, 0, 3);
    step('0, 0, 0, '0, 1, 3);
    step('0, 0, 0, '0, 1, 4);

    step(7'h08, 0, 0, '0, 0, 4);              // R4: fault still active at read
    step(7'h08, 0, 0, '0, 1, 4);
    step('0, 0, 0, '0, 1, 4);
    step('0, 0, 0, '0, 1, 4);

    step(7'h20, 0, 0, '0, 1, 4);              // R4 R5: fault rises in read cycle
    step('0, 0, 0, '0, 1, 5);
    step('0, 0, 0, '0, 1, 5);

    step(7'h01, 0, 1, '0, 0, 7);              // R7: timer mode ignores supply flag
    step('0, 0, 1, '0, 1, 7);
    step('0, 1, 1, '0, 0, 7);
    step('0, 0, 1, '0, 1, 7);
    step('0, 0, 1, '0, 1, 7);
    step('0, 1, 0, '0, 0, 7);                 // R7: supply mode ignores timer
    step('0, 0, 0, '0, 1, 7);

    step('0, 0, 0, 8'h40, 0, 6);              // R6: summary set, survives reads
    step('0, 0, 0, 8'h40, 1, 6);
    step('0, 0, 0, 8'h40, 1, 6);
    step('0, 0, 0, '0, 0, 6);
    step('0, 0, 0, '0, 1, 6);

    step(7'h55, 0, 0, '0, 0, 5);              // R5: pre-clear word with many bits
    step(7'h2A, 0, 0, '0, 1, 5);
    step('0, 0, 0, '0, 1, 5);
    step('0, 0, 0, '0, 1, 5);
    step('0, 0, 0, '0, 0, 5);
    step('0, 0, 0, '0, 0, 5);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule